// File: doc/BRIEF.md
# Framed serial-to-parallel receiver

This block rebuilds an N-bit word that arrives one bit per clock over a two-wire link. The link has a framing line (`cs_i`) and a serial data line (`sdata_i`). When the framing line is seen high while the block is idle, a receive window opens on the next clock edge. From then on, one data bit is captured per cycle, least significant bit first. The window is closed by an internal bit counter and not by the framing line. This matters because the sender drops the framing line in the same cycle that the final data bit is on the wire.

When the last bit is in, the completed word appears on `word_o` and `ready_o` goes high. The word stays there, unchanged, until the consumer raises `ack_i`. The block then returns to idle and waits for the next framed word. During the hold, new framing and data activity on the link is ignored. The parallel output keeps its last word through the next reception and only changes when a new word is complete.

Top module: `srx_top`

## Requirements
- R1: A synchronous active-high reset puts the block in idle with `ready_o` low, `word_o` all zeros and the bit position at 0.
- R2: In idle, `cs_i` high at a clock edge moves the block into reception at that edge. With `cs_i` low, the block stays idle.
- R3: Bits are assembled least significant bit first. The first bit captured after the window opens lands in `word_o[0]` and the k-th lands in `word_o[k-1]`. Example for N=8: 0xC6 arrives as 0,1,1,0,0,0,1,1.
- R4: Reception lasts exactly N clock cycles, capturing one bit on each cycle. The edge that captures bit N-1 ends reception even if `cs_i` is already low. `ready_o` is low during all N cycles and high right after the N-th capture edge.
- R5: When reception ends, `ready_o` goes high and `word_o` shows the complete word in the same cycle.
- R6: While `ready_o` is high and `ack_i` is low, `ready_o` stays high and `word_o` does not change. `ack_i` high at an edge while holding clears `ready_o` and returns the block to idle at that edge.
- R7: While holding a word, `cs_i` and `sdata_i` have no effect. A new frame is recognised only after the block has returned to idle.
- R8: `word_o` changes only in the cycle where `ready_o` rises. It keeps the previous word during the following idle time and during the next reception.
- R9: `ack_i` has no effect while the block is idle or receiving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| cs_i | input | 1 | Framing line from the sender; opens a receive window |
| sdata_i | input | 1 | Serial data, least significant bit first |
| word_o | output | N | Last completely received word |
| ready_o | output | 1 | High while a received word waits for acknowledge |
| ack_i | input | 1 | Consumer acknowledge; releases the held word |

## Verification
The bench drives frames exactly the way the sender does, with the framing line dropped during the last bit. A design that ends reception on the falling framing line would lose the top bit and raise `ready_o` one cycle too early or too late. Words such as 0x01 and 0x80 expose a reversed bit order. Pulses on the framing line and toggling data during the hold are aimed at a design that restarts on `cs_i` without waiting for acknowledge; such a design would drop `ready_o` or corrupt `word_o`. Acknowledge pulses while idle or receiving, and checks of `word_o` during the next frame, catch a design that reacts to a stray acknowledge or exposes a half-built word.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_HOLD = 2'd2
    } srx_state_e;
endpackage

// File: rtl/srx_shift.sv
// Staging register: writes one serial bit per capture cycle at the given
// position and offers the merged word (including the bit on the line now).
module srx_shift #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          cap_en_i,
    input  logic [IW-1:0] pos_i,
    input  logic          bit_i,
    output logic [N-1:0]  merged_o
);
    logic [N-1:0] stage_d, stage_q;

    always_comb begin
        merged_o        = stage_q;
        merged_o[pos_i] = bit_i;
        stage_d         = cap_en_i ? merged_o : stage_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) stage_q <= '0;
        else       stage_q <= stage_d;
    end
endmodule

// File: rtl/srx_outreg.sv
// Parallel output register: loads only when a word completes.
module srx_outreg #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [N-1:0] din_i,
    output logic [N-1:0] dout_o
);
    logic [N-1:0] out_d, out_q;

    always_comb out_d = load_i ? din_i : out_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) out_q <= '0;
        else       out_q <= out_d;
    end

    assign dout_o = out_q;
endmodule

// File: rtl/srx_top.sv
module srx_top #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         cs_i,
    input  logic         sdata_i,
    output logic [N-1:0] word_o,
    output logic         ready_o,
    input  logic         ack_i
);
    import srx_pkg::*;

    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST_POS = IW'(N - 1);

    typedef struct packed {
        srx_state_e    st;
        logic [IW-1:0] pos;
        logic          rdy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic cap_en, load_en;
    logic [N-1:0] merged;

    // Observation points for the bound checker
    logic [1:0]    st_w;
    logic [IW-1:0] pos_w;

    always_comb begin
        ctl_d   = ctl_q;
        cap_en  = 1'b0;
        load_en = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.pos = '0;
                if (cs_i) ctl_d.st = ST_READ;
            end
            ST_READ: begin
                cap_en = 1'b1;
                if (ctl_q.pos == LAST_POS) begin
                    load_en   = 1'b1;
                    ctl_d.st  = ST_HOLD;
                    ctl_d.rdy = 1'b1;
                    ctl_d.pos = '0;
                end else begin
                    ctl_d.pos = ctl_q.pos + 1'b1;
                end
            end
            ST_HOLD: begin
                if (ack_i) begin
                    ctl_d.rdy = 1'b0;
                    ctl_d.st  = ST_IDLE;
                end
            end
            default: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.pos = '0;
                ctl_d.rdy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q.st  <= ST_IDLE;
            ctl_q.pos <= '0;
            ctl_q.rdy <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    srx_shift #(.N(N), .IW(IW)) shift_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .cap_en_i (cap_en),
        .pos_i    (ctl_q.pos),
        .bit_i    (sdata_i),
        .merged_o (merged)
    );

    srx_outreg #(.N(N)) outreg_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load_en),
        .din_i  (merged),
        .dout_o (word_o)
    );

    assign ready_o = ctl_q.rdy;
    assign st_w    = ctl_q.st;
    assign pos_w   = ctl_q.pos;
endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
    parameter int N = 8
) (
    input logic                         clk_i,
    input logic                         rst_i,
    input logic                         cs_i,
    input logic                         ack_i,
    input logic                         ready_o,
    input logic [N-1:0]                 word_o,
    input logic [1:0]                   st_i,
    input logic [((N>1)?$clog2(N):1)-1:0] pos_i
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [1:0] S_IDLE = 2'd0;
    localparam logic [1:0] S_READ = 2'd1;
    localparam logic [1:0] S_HOLD = 2'd2;

    int rd_cnt;
    always_ff @(posedge clk_i) begin
        if (rst_i)               rd_cnt <= 0;
        else if (st_i == S_READ) rd_cnt <= rd_cnt + 1;
        else                     rd_cnt <= 0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        rst_i |=> (st_i == S_IDLE && !ready_o && word_o == '0 && pos_i == '0));

    // R2
    idle_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == S_IDLE && cs_i) |=> (st_i == S_READ));

    // R2
    idle_stay_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == S_IDLE && !cs_i) |=> (st_i == S_IDLE));

    // R3
    pos_track_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == S_READ) |-> (int'(pos_i) == rd_cnt));

    // R4
    read_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ready_o) |-> (rd_cnt == N));

    // R6
    hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ready_o && !ack_i) |=> (ready_o && $stable(word_o)));

    // R6
    ack_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ready_o && ack_i) |=> (!ready_o && st_i == S_IDLE));

    // R7
    hold_ignore_cs_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == S_HOLD) |=> (st_i != S_READ));

    // R8
    word_change_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(word_o) |-> $rose(ready_o));

    // R9
    ack_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == S_READ && ack_i) |=> (st_i == S_READ || st_i == S_HOLD));
endmodule

bind srx_top srx_chk #(.N(N)) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .cs_i    (cs_i),
    .ack_i   (ack_i),
    .ready_o (ready_o),
    .word_o  (word_o),
    .st_i    (st_w),
    .pos_i   (pos_w)
);

// File: tb/srx_top_tb_top.sv
module srx_top_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs = 1'b0;
    logic         sdata = 1'b0;
    logic         ack = 1'b0;
    logic [N-1:0] word;
    logic         ready;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [N-1:0] exp_q[$];
    logic [N-1:0] last_word = '0;
    logic         prev_ready = 1'b0;

    always #5 clk = ~clk;

    srx_top #(.N(N)) dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .cs_i    (cs),
        .sdata_i (sdata),
        .word_o  (word),
        .ready_o (ready),
        .ack_i   (ack)
    );

    task automatic check(input bit ok, input string req, input logic [N-1:0] act,
                         input logic [N-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    // Monitor: pops the scoreboard whenever a word is presented
    always @(negedge clk) begin
        if (!rst) begin
            if (ready && !prev_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected word", word, '0);
                end else begin
                    logic [N-1:0] e;
                    e = exp_q.pop_front();
                    check(word == e, "R3/R5 received word", word, e);
                end
            end
            prev_ready = ready;
        end
    end

    // Driver: frames a word like the sender, cs dropped during the last bit
    task automatic send_word(input logic [N-1:0] w, input bit ack_noise);
        exp_q.push_back(w);
        @(negedge clk);
        cs = 1'b1;
        sdata = 1'b0;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            check(ready == 1'b0, "R4 ready low during reception", {{(N-1){1'b0}}, ready}, '0);
            check(word == last_word, "R8 word held during reception", word, last_word);
            sdata = w[i];
            cs    = (i < N - 1);
            ack   = ack_noise;
        end
        @(negedge clk);
        ack = 1'b0;
        cs  = 1'b0;
        check(ready == 1'b1, "R4 ready after N captures (R9 ack ignored)",
              {{(N-1){1'b0}}, ready}, {{(N-1){1'b0}}, 1'b1});
        last_word = w;
    endtask

    task automatic hold_and_ack(input int cycles, input bit link_noise);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check(ready == 1'b1, "R6/R7 ready held", {{(N-1){1'b0}}, ready},
                  {{(N-1){1'b0}}, 1'b1});
            check(word == last_word, "R6/R7 word stable while held", word, last_word);
            if (link_noise) begin
                cs    = ~cs;
                sdata = ~sdata;
            end
        end
        @(negedge clk);
        cs  = 1'b0;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(ready == 1'b0, "R6 ready cleared by ack", {{(N-1){1'b0}}, ready}, '0);
        check(word == last_word, "R8 word kept after ack", word, last_word);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(ready == 1'b0, "R1 ready after reset", {{(N-1){1'b0}}, ready}, '0);
        check(word == '0, "R1 word after reset", word, '0);

        // R9 / R2: ack pulses while idle, cs low: nothing happens
        ack = 1'b1;
        repeat (4) @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        check(ready == 1'b0, "R9 ack in idle ignored (R2 stay idle)",
              {{(N-1){1'b0}}, ready}, '0);
        check(word == '0, "R9 word untouched", word, '0);

        send_word(8'hC6, 1'b0); hold_and_ack(3, 1'b0);
        send_word(8'h2D, 1'b0); hold_and_ack(0, 1'b0);
        send_word(8'h01, 1'b1); hold_and_ack(2, 1'b0);
        send_word(8'h80, 1'b0); hold_and_ack(N + 3, 1'b1);
        send_word(8'hFF, 1'b0); hold_and_ack(1, 1'b1);
        send_word(8'h00, 1'b1); hold_and_ack(4, 1'b0);
        send_word(8'hA5, 1'b0); hold_and_ack(5, 1'b1);

        // R8: idle afterwards, output keeps last word
        for (int i = 0; i < N + 3; i++) begin
            @(negedge clk);
            check(ready == 1'b0, "R2 stays idle with cs low", {{(N-1){1'b0}}, ready}, '0);
            check(word == last_word, "R8 word held in idle", word, last_word);
        end
        check(exp_q.size() == 0, "R5 all words delivered", N'(exp_q.size()), '0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule